// File: doc/BRIEF.md
# Programmable Cascaded Clock Divider

This block turns a fast input clock into a slow periodic strobe. An 8-bit binary divide ratio N is presented on the ratio input. A chain of two 4-bit down-counting digits is loaded with N. The low digit steps on every clock. The high digit steps only when the low digit passes from zero, so it works as a borrow-driven digit. When the combined count reaches one, the block raises its output strobe for one clock and reloads N into every digit. The strobe therefore repeats every N input clocks, and its rate is the input rate divided by N.

The ratio is sampled only at a reload. A new value can be written at any time and takes effect from the next period. A ratio of zero has no meaning. If a reload picks up zero, the block raises a warning flag that stays high until a later reload samples a non-zero ratio. While zero is loaded the chain wraps and spends 256 clocks before it reloads. Digit width and digit count are parameters, and the default is two 4-bit digits.

Top module: `clkdiv_cascade`

## Requirements
- R1: While reset is high the strobe is low and the zero-ratio flag is low. Reset takes effect on the next clock edge and clears every digit to 0.
- R2: The first clock edge after reset is released loads the ratio N. The strobe is first high in the cycle that follows the N-th edge after release.
- R3: Once running, the strobe is high in exactly one cycle out of every N for each N from 1 to 255. For N = 1 it is high in every cycle.
- R4: For N of 2 or more, the strobe is high for exactly one cycle per period.
- R5: A change to the ratio in the middle of a period leaves that period's length unchanged. The new ratio sets the length of the following period.
- R6: The largest ratio, all ones (255), gives a period of 255 clocks.
- R7: When a reload samples a ratio of zero, the zero-ratio flag goes high after that edge and the period lasts 256 clocks. The flag falls after the next reload that samples a non-zero ratio.
- R8: Asserting reset in the middle of a period drops the strobe. After release the block restarts with the full first-pulse delay of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| ratio | input | 8 | Binary divide ratio N, sampled at each reload |
| tick_out | output | 1 | One-cycle strobe, once per N clocks |
| ratio_zero | output | 1 | High while the last reload sampled a zero ratio |

## Verification
The hardest state to reach is a zero ratio. Nothing at the ports shows the count wrapping from 0 through 255, and the flag can only be cleared by a reload that occurs 256 clocks later. The bench loads zero and swaps in a legal ratio partway through that long period. It then checks that the flag holds until that reload and that the next period runs at the new ratio. A full sweep of every legal ratio, each checked from reset release through one complete period, exercises every borrow from the low digit into the high digit.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // one step down of a single digit, wrapping from zero to all ones
  function automatic logic [31:0] digit_step(input logic [31:0] d, input int unsigned w);
    logic [31:0] mask;
    mask = (32'd1 << w) - 32'd1;
    return (d - 32'd1) & mask;
  endfunction

  // lowest digit at the value that marks the last cycle of a period
  function automatic logic low_digit_final(input logic [31:0] d);
    return d == 32'd1;
  endfunction

endpackage

// File: rtl/cd_digit.sv
module cd_digit #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          dec_in,
  output logic [DW-1:0] digit,
  output logic          is_zero,
  output logic          borrow_out
);
  import clkdiv_pkg::*;

  logic [31:0] stepped;

  always_comb begin
    stepped    = digit_step(32'(digit), DW);
    is_zero    = (digit == '0);
    borrow_out = dec_in & is_zero;
  end

  always_ff @(posedge clk) begin
    if (rst)         digit <= '0;
    else if (load)   digit <= load_val;
    else if (dec_in) digit <= stepped[DW-1:0];
  end
endmodule

// File: rtl/cd_term.sv
module cd_term #(
  parameter int DW     = 4,
  parameter int STAGES = 2
) (
  input  logic [DW*STAGES-1:0] count,
  output logic                 term
);
  import clkdiv_pkg::*;

  logic [STAGES-1:0] part_ok;

  assign part_ok[0] = low_digit_final(32'(count[DW-1:0]));

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_upper
      assign part_ok[i] = (count[i*DW +: DW] == '0);
    end
  endgenerate

  assign term = &part_ok;
endmodule

// File: rtl/cd_sequencer.sv
module cd_sequencer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ratio,
  input  logic         term,
  output logic         load,
  output logic         armed,
  output logic         zero_flag
);
  always_comb load = ~armed | term;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      zero_flag <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (load) zero_flag <= (ratio == '0);
    end
  end
endmodule

// File: rtl/clkdiv_cascade.sv
module clkdiv_cascade #(
  parameter int DIGIT_W = 4,
  parameter int STAGES  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [DIGIT_W*STAGES-1:0] ratio,
  output logic                      tick_out,
  output logic                      ratio_zero
);
  localparam int W = DIGIT_W * STAGES;

  logic [W-1:0]      count;
  logic [STAGES:0]   dec_chain;
  logic [STAGES-1:0] dig_zero;
  logic              load;
  logic              armed;
  logic              term;

  cd_sequencer #(.W(W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .ratio     (ratio),
    .term      (term),
    .load      (load),
    .armed     (armed),
    .zero_flag (ratio_zero)
  );

  assign dec_chain[0] = armed;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_digit
      cd_digit #(.DW(DIGIT_W)) u_digit (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .load_val   (ratio[i*DIGIT_W +: DIGIT_W]),
        .dec_in     (dec_chain[i]),
        .digit      (count[i*DIGIT_W +: DIGIT_W]),
        .is_zero    (dig_zero[i]),
        .borrow_out (dec_chain[i+1])
      );
    end
  endgenerate

  cd_term #(.DW(DIGIT_W), .STAGES(STAGES)) u_term (
    .count (count),
    .term  (term)
  );

  assign tick_out = armed & term;
endmodule

// File: rtl/clkdiv_cascade_chk.sv
module clkdiv_cascade_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] ratio,
  input logic         tick_out,
  input logic         ratio_zero,
  input logic [W-1:0] count,
  input logic         armed,
  input logic         load
);
  // R1: a reset edge clears the chain and silences the strobe
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (count == '0 && !tick_out && !ratio_zero));

  // R2: arming loads the ratio seen at that edge
  p_first_load_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> count == $past(ratio));

  // R3: between reloads the chain steps down by exactly one
  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && !tick_out) |=> count == $past(count) - 1'b1);

  // R4: a strobe is followed by another only for a ratio of one
  p_tick_single_r4: assert property (@(posedge clk) disable iff (rst)
    tick_out |=> (tick_out == ($past(ratio) == 1)));

  // R5: the strobe edge reloads the ratio present at that edge
  p_reload_r5: assert property (@(posedge clk) disable iff (rst)
    tick_out |=> count == $past(ratio));

  // R7: a reload of zero raises the warning flag
  p_zero_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (load && ratio == '0) |=> ratio_zero);
endmodule

bind clkdiv_cascade clkdiv_cascade_chk #(.W(DIGIT_W*STAGES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ratio      (ratio),
  .tick_out   (tick_out),
  .ratio_zero (ratio_zero),
  .count      (count),
  .armed      (armed),
  .load       (load)
);

// File: tb/tb_clkdiv_cascade.sv
module tb_clkdiv_cascade;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] ratio = 8'd1;
  logic       tick_out;
  logic       ratio_zero;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  clkdiv_cascade dut (
    .clk        (clk),
    .rst        (rst),
    .ratio      (ratio),
    .tick_out   (tick_out),
    .ratio_zero (ratio_zero)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input int n);
    rst   = 1'b1;
    ratio = 8'(n);
    step();
    step();
    chk(tick_out == 1'b0, "R1 strobe in reset", int'(tick_out), 0);
    chk(ratio_zero == 1'b0, "R1 flag in reset", int'(ratio_zero), 0);
    rst = 1'b0;
  endtask

  // N edges; strobe expected only after the last one
  task automatic window(input int n, input string req);
    for (int k = 1; k <= n; k++) begin
      step();
      chk(tick_out == (k == n), req, int'(tick_out), int'(k == n));
    end
  endtask

  initial begin
    step();
    // R2 R3 R4 R6: sweep every legal ratio
    for (int n = 1; n <= 255; n++) begin
      do_reset(n);
      window(n, "R2 first strobe");
      window(n, (n == 255) ? "R6 max ratio period" : "R3 R4 period");
    end

    // R5: change ratio mid period
    do_reset(10);
    for (int k = 1; k <= 3; k++) begin
      step();
      chk(tick_out == 1'b0, "R5 early", int'(tick_out), 0);
    end
    ratio = 8'd6;
    for (int k = 4; k <= 10; k++) begin
      step();
      chk(tick_out == (k == 10), "R5 old period kept", int'(tick_out), int'(k == 10));
    end
    window(6, "R5 new period");

    // R7: zero ratio loaded
    do_reset(0);
    step();
    chk(ratio_zero == 1'b1, "R7 flag raised", int'(ratio_zero), 1);
    for (int k = 2; k <= 256; k++) begin
      if (k == 100) ratio = 8'd5;
      step();
      chk(tick_out == (k == 256), "R7 wrap period", int'(tick_out), int'(k == 256));
      if (k == 255) chk(ratio_zero == 1'b1, "R7 flag held", int'(ratio_zero), 1);
    end
    window(5, "R7 period after zero");
    chk(ratio_zero == 1'b0, "R7 flag cleared", int'(ratio_zero), 0);

    // R8: reset mid period
    do_reset(7);
    for (int k = 1; k <= 4; k++) step();
    rst = 1'b1;
    step();
    chk(tick_out == 1'b0, "R8 strobe dropped", int'(tick_out), 0);
    rst = 1'b0;
    window(7, "R8 restart first strobe");
    window(7, "R8 restart period");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule